// File: doc/BRIEF.md
# Four-Level Frame-Rate Gray Modulator

This block turns a row of 2-bit pixel codes into per-column drive selections for a passive matrix panel. Four gray shades are produced by frame-rate control. Over a cycle of three frames, a pixel of level n is driven "on" in exactly n of those frames. To keep the flicker from lining up across the panel, the frame in which a pixel fires is shifted by its position inside a tile that is 3 columns wide and 3 lines tall.

The row of pixel codes and the current line number are inputs that are already latched. The block owns the frame-phase state machine. It has three states, `PH_0`, `PH_1` and `PH_2`. Reset puts it in `PH_0`. Each cycle with `frame_tick` high takes the transition `PH_0`→`PH_1`, `PH_1`→`PH_2` or `PH_2`→`PH_0`. In any other cycle the state holds.

A polarity input picks which end of the code range is black. An active-low blank input forces every column to the display-off level. Each column's 2-bit output is combinational from the phase state and the inputs.

Top module: `frc_pixel_modulator`

## Requirements
- R1: After reset the frame phase is 0. With every pixel at code 01, line 0 and no blanking, column 0 drives on.
- R2: The phase advances 0→1→2→0 by one step on each clock edge where `frame_tick` is high. It holds on every other edge.
- R3: Over any three consecutive phases, a pixel of gray level L (0..3) drives on in exactly L of them.
- R4: A pixel at column c on line l, with phase p and level L, drives on exactly when ((c mod 3) + (l mod 3) + p) mod 3 < L.
- R5: With `gray_flip` low, the gray level equals the pixel code. Code 11 is always on (black) and code 00 is always off.
- R6: With `gray_flip` high, the gray level is 3 minus the code. Code 00 is always on, code 11 is always off, and code 01 behaves as level 2.
- R7: Per column, drive code 00 means on (V0) and 01 means off (V1). Code 11 never appears.
- R8: While `blank_n` is low, every column outputs 10 (V2, display off) whatever the pixel data. Frame ticks during blanking still advance the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse marking a new frame |
| line_idx | input | LINE_W | Index of the line being driven |
| row_pix | input | 2*NUM_COLS | Pixel codes; column k is in bits [2k+1:2k] |
| gray_flip | input | 1 | Gray polarity: 0 means code 11 is black, 1 means code 11 is white |
| blank_n | input | 1 | Active-low display-off |
| drv_code | output | 2*NUM_COLS | Drive selection per column, in the same bit layout as row_pix |

## Verification
A frame tick can arrive in the same cycle as display-off. Display-off must win at the outputs, but the phase state must still take its transition. The bench raises `frame_tick` while `blank_n` is low and checks that every column shows the display-off code. It then releases blanking and compares the whole row against a model whose phase has moved one step. This exposes a design that freezes the phase while blanked, and also one that lets pixel data leak through the blanking.

// File: rtl/frc_pkg.sv
package frc_pkg;
    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2
    } frc_phase_e;

    localparam logic [1:0] DRV_ON    = 2'b00;
    localparam logic [1:0] DRV_OFF   = 2'b01;
    localparam logic [1:0] DRV_BLANK = 2'b10;

    function automatic logic [1:0] add_mod3(input logic [1:0] a, input logic [1:0] b);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, b};
        return (s >= 3'd3) ? 2'(s - 3'd3) : s[1:0];
    endfunction
endpackage

// File: rtl/frc_phase_fsm.sv
module frc_phase_fsm
    import frc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_tick,
    output frc_phase_e phase
);
    frc_phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        if (frame_tick) begin
            unique case (phase_q)
                PH_0:    phase_d = PH_1;
                PH_1:    phase_d = PH_2;
                PH_2:    phase_d = PH_0;
                default: phase_d = PH_0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_0;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> (2'(phase_q) == add_mod3(2'($past(phase_q)), 2'd1))); // R2
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(phase_q)); // R2
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        2'(phase_q) != 2'd3); // R2
endmodule

// File: rtl/frc_pixel_cell.sv
module frc_pixel_cell
    import frc_pkg::*;
#(
    parameter int COL_IDX = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pix,
    input  logic       gray_flip,
    input  logic       blank_n,
    input  logic [1:0] row_base,
    output logic [1:0] drv
);
    localparam logic [1:0] COL_M3 = 2'(COL_IDX % 3);

    logic [1:0] level;
    logic [1:0] offset;
    logic       fire;

    always_comb begin
        level  = gray_flip ? ~pix : pix;
        offset = add_mod3(row_base, COL_M3);
        fire   = ({1'b0, offset} < {1'b0, level});
        if (!blank_n)  drv = DRV_BLANK;
        else if (fire) drv = DRV_ON;
        else           drv = DRV_OFF;
    end

    AST_BLANK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> drv == DRV_BLANK); // R8
    AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        drv != 2'b11); // R7
    AST_BLACK_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && pix == (gray_flip ? 2'b00 : 2'b11)) |-> drv == DRV_ON); // R5
    AST_WHITE_ALWAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && pix == (gray_flip ? 2'b11 : 2'b00)) |-> drv == DRV_OFF); // R6
endmodule

// File: rtl/frc_pixel_modulator.sv
module frc_pixel_modulator
    import frc_pkg::*;
#(
    parameter int NUM_COLS = 160,
    parameter int LINE_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_tick,
    input  logic [LINE_W-1:0]       line_idx,
    input  logic [2*NUM_COLS-1:0]   row_pix,
    input  logic                    gray_flip,
    input  logic                    blank_n,
    output logic [2*NUM_COLS-1:0]   drv_code
);
    localparam int PIX_W = 2;

    frc_phase_e phase;
    logic [1:0] line_m3;
    logic [1:0] row_base;

    frc_phase_fsm u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .phase      (phase)
    );

    // Line index modulo 3, folded bit by bit from the MSB down.
    always_comb begin
        logic [2:0] t;
        line_m3 = 2'd0;
        for (int i = LINE_W - 1; i >= 0; i--) begin
            t = {line_m3, line_idx[i]};
            line_m3 = (t >= 3'd3) ? 2'(t - 3'd3) : t[1:0];
        end
        row_base = add_mod3(line_m3, 2'(phase));
    end

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        frc_pixel_cell #(.COL_IDX(c)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .pix       (row_pix[PIX_W*c +: PIX_W]),
            .gray_flip (gray_flip),
            .blank_n   (blank_n),
            .row_base  (row_base),
            .drv       (drv_code[PIX_W*c +: PIX_W])
        );
    end

    AST_BASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        row_base != 2'd3); // R4
endmodule

// File: tb/test_frc_pixel_modulator.sv
module test_frc_pixel_modulator;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 160;
    localparam int LW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_tick = 1'b0;
    logic [LW-1:0]     line_idx = '0;
    logic [2*NC-1:0]   row_pix = '0;
    logic              gray_flip = 1'b0;
    logic              blank_n = 1'b1;
    logic [2*NC-1:0]   drv_code;

    int checks = 0;
    int fails  = 0;
    int mphase = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frc_pixel_modulator #(.NUM_COLS(NC), .LINE_W(LW)) i_frc_pixel_modulator (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .line_idx(line_idx),
        .row_pix(row_pix), .gray_flip(gray_flip), .blank_n(blank_n), .drv_code(drv_code)
    );

    function automatic logic [1:0] model(int c, int l, int p, logic [1:0] px, logic fl, logic bn);
        int lvl;
        int off;
        if (!bn) return 2'b10;
        lvl = fl ? 3 - int'(px) : int'(px);
        off = (c % 3 + l % 3 + p) % 3;
        return (off < lvl) ? 2'b00 : 2'b01;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_row(string req);
        int bad = -1;
        logic [1:0] e;
        #1;
        for (int c = 0; c < NC; c++) begin
            e = model(c, int'(line_idx), mphase, row_pix[2*c +: 2], gray_flip, blank_n);
            if (drv_code[2*c +: 2] !== e && bad < 0) bad = c;
        end
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s column %0d: actual %0h expected %0h", req, bad, drv_code[2*bad +: 2],
                     model(bad, int'(line_idx), mphase, row_pix[2*bad +: 2], gray_flip, blank_n));
        end
    endtask

    task automatic fill(int seed);
        for (int c = 0; c < NC; c++) row_pix[2*c +: 2] = 2'((c * 7 + seed * 3 + c / 5) & 3);
    endtask

    task automatic fill_all(logic [1:0] v);
        for (int c = 0; c < NC; c++) row_pix[2*c +: 2] = v;
    endtask

    task automatic tick();
        @(negedge clk) frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
        mphase = (mphase + 1) % 3;
    endtask

    task automatic t_reset();
        fill_all(2'b01);
        line_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1", 32'(drv_code[1:0]), 32'h0, "column 0 on after reset");
        check_row("R1");
    endtask

    task automatic t_phase_walk();
        fill(1);
        line_idx = 8'd4;
        for (int k = 0; k < 4; k++) begin
            tick();
            check_row("R2");
        end
        repeat (5) @(negedge clk);
        check_row("R2");
    endtask

    task automatic t_levels();
        int ons;
        line_idx = '0;
        for (int lv = 0; lv < 4; lv++) begin
            fill_all(2'(lv));
            ons = 0;
            for (int k = 0; k < 3; k++) begin
                #1;
                if (drv_code[1:0] == 2'b00) ons++;
                tick();
            end
            check("R3", 32'(ons), 32'(lv), "on frames per cycle");
        end
    endtask

    task automatic t_lines();
        for (int l = 0; l < 6; l++) begin
            line_idx = 8'(l);
            fill(l + 2);
            @(negedge clk);
            check_row("R4");
        end
        line_idx = 8'd239;
        fill(9);
        tick();
        check_row("R4");
        line_idx = 8'd255;
        @(negedge clk);
        check_row("R4");
    endtask

    task automatic t_polarity();
        gray_flip = 1'b0;
        fill_all(2'b11); @(negedge clk); #1;
        check("R5", 32'(drv_code), 32'h0, "code 11 black (low bits)");
        check_row("R5");
        fill_all(2'b00); @(negedge clk);
        check_row("R5");
        gray_flip = 1'b1;
        fill_all(2'b00); @(negedge clk);
        check_row("R6");
        fill_all(2'b11); tick();
        check_row("R6");
        fill_all(2'b01); line_idx = '0;
        for (int k = 0; k < 3; k++) begin
            check_row("R6");
            tick();
        end
        fill(5); check_row("R6");
        gray_flip = 1'b0;
    endtask

    task automatic t_codes();
        bit seen11;
        for (int s = 0; s < 4; s++) begin
            fill(s + 11);
            line_idx = 8'(s * 13);
            tick();
            #1;
            seen11 = 0;
            for (int c = 0; c < NC; c++) if (drv_code[2*c +: 2] == 2'b11) seen11 = 1;
            check("R7", 32'(seen11), 32'h0, "illegal code 11 seen");
            check_row("R7");
        end
    endtask

    task automatic t_blank();
        fill(3);
        line_idx = 8'd7;
        blank_n = 1'b0;
        @(negedge clk);
        check_row("R8");
        // frame tick in the same cycle as display-off
        frame_tick = 1'b1;
        #1;
        check_row("R8");
        @(negedge clk) frame_tick = 1'b0;
        mphase = (mphase + 1) % 3;
        check_row("R8");
        blank_n = 1'b1;
        @(negedge clk);
        check_row("R8");
    endtask

    initial begin
        t_reset();
        t_phase_walk();
        t_levels();
        t_lines();
        t_polarity();
        t_codes();
        t_blank();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule